// File: doc/BRIEF.md
# Display Processor CPU Port

This block is the processor-facing side of a tile-based display processor. The CPU sees two byte-wide ports, selected by one bit. The control port takes a two-byte command. The data port streams bytes to and from the video memory, or into the colour table, at an address that steps on its own after each access. A control-port read returns a status byte and clears the pending interrupt state.

The block holds the 14-bit access address and the 2-bit access code. It also holds the byte toggle for the control port, a one-byte read-ahead buffer, sixteen 8-bit mode registers, a 32-entry colour table and the interrupt logic. Line and frame events and the other status bits come in as single-cycle pulses from the rendering side. The rendering side reads mode registers and colour entries through two side ports.

The video memory is an internal array of `2**MEM_AW` bytes. The address counter is always 14 bits wide. With the default `MEM_AW` of 12, addresses alias every 4 KB. Set `MEM_AW` to 14 to give the full 16 KB.

Top module: `vdp_cpu_port`

## Requirements
- R1: After synchronous reset, `cpu_rdata` is 0, `irq` is 0, every mode register and colour entry reads 0, and the next control write is taken as a first byte.
- R2: Control writes alternate between first and second byte. A first byte replaces address bits 7:0. A second byte replaces address bits 13:8 with its bits 5:0, and loads the access code from its bits 7:6.
- R3: A second control byte with code 0 loads the read buffer from memory at the new address, and then steps the address by one.
- R4: A second control byte with code 2 loads the mode register indexed by its bits 3:0 with the preceding first byte. The address is still updated as R2 states.
- R5: A data-port read (`cpu_sel`=0) returns the buffer contents on `cpu_rdata` in the next cycle. The buffer then reloads from memory at the current address, and the address steps by one.
- R6: A data-port write stores into the colour table at address bits 4:0 when the code is 3. The entry keeps bits 5:0 as red in 1:0, green in 3:2 and blue in 5:4. With any other code the byte goes to video memory. In both cases the byte is also copied into the read buffer.
- R7: Every data-port access clears the control-byte toggle. The address steps modulo 16384, so 0x3FFF wraps to 0.
- R8: A control-port read (`cpu_sel`=1) returns the frame-pending flag in bit 7 and the latched status bits in 6:0. When mode register 0 bit 2 is set, bits 4:0 read as ones.
- R9: A control-port read clears the toggle, both pending flags and the status bits, which drops `irq`. An event that arrives in the same cycle still sets its flag.
- R10: `irq` is high while (frame pending and register 1 bit 5) or (line pending and register 0 bit 4). Writing the enable bit while a flag is pending raises `irq` on the next cycle.
- R11: A write strobe takes priority over a read strobe given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_sel | input | 1 | Port select: 0 data, 1 control |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Registered read byte, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt request level |
| line_evt | input | 1 | Line interrupt event pulse |
| frame_evt | input | 1 | Frame interrupt event pulse |
| stat_evt | input | 7 | Status bit set pulses, ORed into status bits 6:0 |
| reg_sel | input | 4 | Mode register index for the render side |
| reg_val | output | 8 | Selected mode register |
| cram_sel | input | 5 | Colour table index for the render side |
| cram_val | output | 6 | Selected colour entry |

## Verification
A wrong toggle shows up at once: the next control byte lands in the wrong half of the address, or loads the wrong register. The first data read after that returns a byte from another location. A stale buffer or a wrong address step shows on `cpu_rdata` in the cycle after the next data read. Wrong pending state shows on `irq` one cycle after an event, an enable write or a status read. The bench keeps a behavioural model and compares `cpu_rdata` and `irq` on every clock. It then reads the side ports after register and colour writes.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

    typedef enum logic [1:0] {
        ACC_MEM_FETCH = 2'd0,
        ACC_MEM_STORE = 2'd1,
        ACC_REG_LOAD  = 2'd2,
        ACC_PAL_STORE = 2'd3
    } acc_code_e;

    typedef struct packed {
        logic [1:0] blue;
        logic [1:0] green;
        logic [1:0] red;
    } pal_entry_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_data;
        logic rd_ctrl;
        logic rd_data;
    } port_op_t;

    // write beats read when both strobes arrive together
    function automatic port_op_t decode_op(input logic rd, input logic wr, input logic sel);
        port_op_t o;
        o.wr_ctrl = wr & sel;
        o.wr_data = wr & ~sel;
        o.rd_ctrl = rd & ~wr & sel;
        o.rd_data = rd & ~wr & ~sel;
        return o;
    endfunction

    function automatic logic [7:0] status_byte(input logic frame_pend,
                                               input logic [6:0] bits,
                                               input logic force_low);
        logic [7:0] s;
        s = {frame_pend, bits};
        if (force_low) s[4:0] = 5'h1f;
        return s;
    endfunction

endpackage

// File: rtl/vdp_vram.sv
module vdp_vram #(
    parameter int MEM_AW = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vdp_cmd_ctrl.sv
module vdp_cmd_ctrl
    import vdp_port_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 8,
    parameter int MEM_AW   = 12,
    parameter int NUM_REGS = 16,
    parameter int PAL_N    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  port_op_t                    op,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic [MEM_AW-1:0]           mem_raddr,
    output logic                        mem_we,
    output logic [MEM_AW-1:0]           mem_waddr,
    output logic                        reg_we,
    output logic [$clog2(NUM_REGS)-1:0] reg_idx,
    output logic [DATA_W-1:0]           reg_wval,
    output logic                        pal_we,
    output logic [$clog2(PAL_N)-1:0]    pal_idx,
    output logic [ADDR_W-1:0]           addr_q,
    output logic                        tog_q,
    output logic [DATA_W-1:0]           rbuf_q
);
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int RIDX_W = $clog2(NUM_REGS);
    localparam int PIDX_W = $clog2(PAL_N);

    acc_code_e           code_q;
    acc_code_e           new_code;
    logic [ADDR_W-1:0]   hi_addr;

    assign new_code  = acc_code_e'(wdata[DATA_W-1 -: 2]);
    assign hi_addr   = {wdata[HI_W-1:0], addr_q[DATA_W-1:0]};
    assign mem_raddr = op.wr_ctrl ? hi_addr[MEM_AW-1:0] : addr_q[MEM_AW-1:0];
    assign mem_waddr = addr_q[MEM_AW-1:0];
    assign mem_we    = op.wr_data && code_q != ACC_PAL_STORE;
    assign pal_we    = op.wr_data && code_q == ACC_PAL_STORE;
    assign pal_idx   = addr_q[PIDX_W-1:0];
    assign reg_we    = op.wr_ctrl && tog_q && new_code == ACC_REG_LOAD;
    assign reg_idx   = wdata[RIDX_W-1:0];
    assign reg_wval  = addr_q[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            code_q <= ACC_MEM_FETCH;
            tog_q  <= 1'b0;
            rbuf_q <= '0;
        end else if (op.wr_ctrl) begin
            tog_q <= ~tog_q;
            if (!tog_q) begin
                addr_q[DATA_W-1:0] <= wdata;
            end else begin
                code_q <= new_code;
                if (new_code == ACC_MEM_FETCH) begin
                    rbuf_q <= mem_rdata;
                    addr_q <= hi_addr + 1'b1;
                end else begin
                    addr_q <= hi_addr;
                end
            end
        end else if (op.wr_data) begin
            rbuf_q <= wdata;
            addr_q <= addr_q + 1'b1;
            tog_q  <= 1'b0;
        end else if (op.rd_data) begin
            rbuf_q <= mem_rdata;
            addr_q <= addr_q + 1'b1;
            tog_q  <= 1'b0;
        end else if (op.rd_ctrl) begin
            tog_q <= 1'b0;
        end
    end
endmodule

// File: rtl/vdp_regbank.sv
module vdp_regbank
    import vdp_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int PAL_N    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_we,
    input  logic [$clog2(NUM_REGS)-1:0] reg_idx,
    input  logic [DATA_W-1:0]           reg_wval,
    input  logic                        pal_we,
    input  logic [$clog2(PAL_N)-1:0]    pal_idx,
    input  pal_entry_t                  pal_wval,
    input  logic [$clog2(NUM_REGS)-1:0] reg_sel,
    output logic [DATA_W-1:0]           reg_val,
    input  logic [$clog2(PAL_N)-1:0]    pal_sel,
    output pal_entry_t                  pal_val,
    output logic [DATA_W-1:0]           mode0,
    output logic [DATA_W-1:0]           mode1
);
    logic [DATA_W-1:0] regs [NUM_REGS];
    pal_entry_t        pal  [PAL_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (reg_we) begin
            regs[reg_idx] <= reg_wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAL_N; i++) pal[i] <= '0;
        end else if (pal_we) begin
            pal[pal_idx] <= pal_wval;
        end
    end

    assign reg_val = regs[reg_sel];
    assign pal_val = pal[pal_sel];
    assign mode0   = regs[0];
    assign mode1   = regs[1];
endmodule

// File: rtl/vdp_irq_stat.sv
module vdp_irq_stat #(
    parameter int STAT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              line_evt,
    input  logic              frame_evt,
    input  logic [STAT_W-1:0] stat_evt,
    input  logic              line_en,
    input  logic              frame_en,
    output logic              line_pend,
    output logic              frame_pend,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line_pend  <= 1'b0;
            frame_pend <= 1'b0;
            stat_q     <= '0;
        end else begin
            line_pend  <= (line_pend  & ~clr) | line_evt;
            frame_pend <= (frame_pend & ~clr) | frame_evt;
            stat_q     <= (clr ? '0 : stat_q) | stat_evt;
        end
    end

    assign irq = (frame_pend & frame_en) | (line_pend & line_en);
endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
    import vdp_port_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 8,
    parameter int MEM_AW   = 12,
    parameter int NUM_REGS = 16,
    parameter int PAL_N    = 32,
    parameter int STAT_W   = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cpu_rd,
    input  logic                        cpu_wr,
    input  logic                        cpu_sel,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        irq,
    input  logic                        line_evt,
    input  logic                        frame_evt,
    input  logic [STAT_W-1:0]           stat_evt,
    input  logic [$clog2(NUM_REGS)-1:0] reg_sel,
    output logic [DATA_W-1:0]           reg_val,
    input  logic [$clog2(PAL_N)-1:0]    cram_sel,
    output logic [5:0]                  cram_val
);
    localparam int RIDX_W = $clog2(NUM_REGS);
    localparam int PIDX_W = $clog2(PAL_N);

    port_op_t            op;
    logic [DATA_W-1:0]   mem_rdata;
    logic [MEM_AW-1:0]   mem_raddr;
    logic [MEM_AW-1:0]   mem_waddr;
    logic                mem_we;
    logic                reg_we;
    logic [RIDX_W-1:0]   reg_idx;
    logic [DATA_W-1:0]   reg_wval;
    logic                pal_we;
    logic [PIDX_W-1:0]   pal_idx;
    logic [ADDR_W-1:0]   addr_q;
    logic                tog_q;
    logic [DATA_W-1:0]   rbuf_q;
    logic [DATA_W-1:0]   mode0;
    logic [DATA_W-1:0]   mode1;
    logic                line_pend;
    logic                frame_pend;
    logic [STAT_W-1:0]   stat_q;
    pal_entry_t          pal_val;

    assign op = decode_op(cpu_rd, cpu_wr, cpu_sel);

    vdp_cmd_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
        .NUM_REGS(NUM_REGS), .PAL_N(PAL_N)
    ) u_cmd (
        .clk(clk), .rst(rst), .op(op), .wdata(cpu_wdata),
        .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .mem_we(mem_we), .mem_waddr(mem_waddr),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wval(reg_wval),
        .pal_we(pal_we), .pal_idx(pal_idx),
        .addr_q(addr_q), .tog_q(tog_q), .rbuf_q(rbuf_q)
    );

    vdp_vram #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_vram (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(cpu_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    vdp_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PAL_N(PAL_N)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wval(reg_wval),
        .pal_we(pal_we), .pal_idx(pal_idx), .pal_wval(pal_entry_t'(cpu_wdata[5:0])),
        .reg_sel(reg_sel), .reg_val(reg_val),
        .pal_sel(cram_sel), .pal_val(pal_val),
        .mode0(mode0), .mode1(mode1)
    );

    vdp_irq_stat #(.STAT_W(STAT_W)) u_irq (
        .clk(clk), .rst(rst), .clr(op.rd_ctrl),
        .line_evt(line_evt), .frame_evt(frame_evt), .stat_evt(stat_evt),
        .line_en(mode0[4]), .frame_en(mode1[5]),
        .line_pend(line_pend), .frame_pend(frame_pend),
        .stat_q(stat_q), .irq(irq)
    );

    assign cram_val = pal_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata <= '0;
        end else if (op.rd_data) begin
            cpu_rdata <= rbuf_q;
        end else if (op.rd_ctrl) begin
            cpu_rdata <= status_byte(frame_pend, stat_q, mode0[2]);
        end
    end
endmodule

// File: rtl/vdp_cpu_port_chk.sv
module vdp_cpu_port_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_data,
    input logic              rd_ctrl,
    input logic              wr_data,
    input logic              wr_ctrl,
    input logic [7:0]        wdata,
    input logic              tog,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rbuf,
    input logic [7:0]        rdata,
    input logic              irq,
    input logic              force_low,
    input logic              line_evt,
    input logic              frame_evt
);
    // R7: any data access leaves the toggle clear
    p_tog_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data || wr_data) |=> !tog);

    // R5: data access steps the address by one, modulo the address width
    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data || wr_data) |=> addr == $past(addr) + 1'b1);

    // R5: data read returns the buffer held before the read
    p_rd_buf_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data |=> rdata == $past(rbuf));

    // R2: second byte without fetch places its low bits on the upper address
    p_hi_byte_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && tog && wdata[7:6] != 2'd0) |=>
        addr == {$past(wdata[5:0]), $past(addr[7:0])});

    // R9: status read with no new event drops the request
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && !line_evt && !frame_evt) |=> !irq);

    // R8: low status bits forced when the mode bit is set
    p_stat_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && force_low) |=> rdata[4:0] == 5'h1f);
endmodule

bind vdp_cpu_port vdp_cpu_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .rd_data(op.rd_data), .rd_ctrl(op.rd_ctrl),
    .wr_data(op.wr_data), .wr_ctrl(op.wr_ctrl),
    .wdata(cpu_wdata), .tog(tog_q), .addr(addr_q), .rbuf(rbuf_q),
    .rdata(cpu_rdata), .irq(irq), .force_low(mode0[2]),
    .line_evt(line_evt), .frame_evt(frame_evt)
);

// File: tb/tb_vdp_cpu_port.sv
module tb_vdp_cpu_port;
    localparam int MEMSZ = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_rd = 0, cpu_wr = 0, cpu_sel = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata;
    logic       irq;
    logic       line_evt = 0, frame_evt = 0;
    logic [6:0] stat_evt = 0;
    logic [3:0] reg_sel = 0;
    logic [7:0] reg_val;
    logic [4:0] cram_sel = 0;
    logic [5:0] cram_val;

    always #4 clk = ~clk;

    vdp_cpu_port dut (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .line_evt(line_evt), .frame_evt(frame_evt), .stat_evt(stat_evt),
        .reg_sel(reg_sel), .reg_val(reg_val), .cram_sel(cram_sel), .cram_val(cram_val)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_addr, m_code, m_tog, m_buf, m_rdata, m_lp, m_fp, m_st;
    int m_vram [MEMSZ];
    int m_cram [32];
    int m_regs [16];

    function automatic int m_irq();
        return ((m_fp != 0 && m_regs[1][5]) || (m_lp != 0 && m_regs[0][4])) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_addr = 0; m_code = 0; m_tog = 0; m_buf = 0; m_rdata = 0;
            m_lp = 0; m_fp = 0; m_st = 0;
            for (int i = 0; i < 16; i++) m_regs[i] = 0;
            for (int i = 0; i < 32; i++) m_cram[i] = 0;
        end else begin
            int sb;
            sb = m_fp * 128 + m_st;
            if (m_regs[0][2]) sb = sb | 31;
            if (cpu_wr && cpu_sel) begin
                if (m_tog == 0) begin
                    m_addr = (m_addr / 256) * 256 + cpu_wdata;
                    m_tog = 1;
                end else begin
                    m_code = cpu_wdata / 64;
                    if (m_code == 2) m_regs[cpu_wdata % 16] = m_addr % 256;
                    m_addr = (cpu_wdata % 64) * 256 + m_addr % 256;
                    if (m_code == 0) begin
                        m_buf = m_vram[m_addr % MEMSZ];
                        m_addr = (m_addr + 1) % 16384;
                    end
                    m_tog = 0;
                end
            end else if (cpu_wr) begin
                if (m_code == 3) m_cram[m_addr % 32] = cpu_wdata % 64;
                else m_vram[m_addr % MEMSZ] = cpu_wdata;
                m_buf = cpu_wdata;
                m_addr = (m_addr + 1) % 16384;
                m_tog = 0;
            end else if (cpu_rd && !cpu_sel) begin
                m_rdata = m_buf;
                m_buf = m_vram[m_addr % MEMSZ];
                m_addr = (m_addr + 1) % 16384;
                m_tog = 0;
            end else if (cpu_rd) begin
                m_rdata = sb;
                m_tog = 0; m_fp = 0; m_lp = 0; m_st = 0;
            end
            if (line_evt) m_lp = 1;
            if (frame_evt) m_fp = 1;
            m_st = m_st | stat_evt;
        end
        if (cyc >= 2) cmp_on = 1;
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "rdata", int'(cpu_rdata), m_rdata);
            chk(cur_req, "irq", int'(irq), m_irq());
        end
    end

    task automatic drive(bit r, bit w, bit s, int d);
        @(negedge clk);
        cpu_rd = r; cpu_wr = w; cpu_sel = s; cpu_wdata = d[7:0];
        line_evt = 0; frame_evt = 0; stat_evt = 0;
    endtask
    task automatic idle(); drive(0, 0, 0, 0); endtask
    task automatic ctl(int d); drive(0, 1, 1, d); endtask
    task automatic dwr(int d); drive(0, 1, 0, d); endtask
    task automatic drd(); drive(1, 0, 0, 0); endtask
    task automatic srd(); drive(1, 0, 1, 0); endtask

    task automatic chk_reg(string req, int idx, int exp);
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0; reg_sel = idx[3:0];
        #1 chk(req, "reg_val", int'(reg_val), exp);
    endtask
    task automatic chk_pal(string req, int idx, int exp);
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0; cram_sel = idx[4:0];
        #1 chk(req, "cram_val", int'(cram_val), exp);
    endtask

    initial begin
        #200000;
        while (cyc < 150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        cur_req = "R1";
        chk_reg("R1", 0, 0);
        chk_reg("R1", 1, 0);
        chk_pal("R1", 0, 0);
        chk("R1", "rdata after reset", int'(cpu_rdata), 0);

        // fill memory so every later read is defined (R6 data write path)
        cur_req = "R6";
        ctl(8'h00); ctl(8'h40);
        for (int i = 0; i < MEMSZ; i++) dwr((i * 7 + 3) % 256);
        idle();

        // R4: register load with code 2
        cur_req = "R4";
        ctl(8'h5A); ctl(8'h87); idle();
        chk_reg("R4", 7, 8'h5A);
        ctl(8'h13); ctl(8'h8C); idle();
        chk_reg("R4", 12, 8'h13);

        // R2 / R6: set address 0x0123 with code 1 and store three bytes
        cur_req = "R2";
        ctl(8'h23); ctl(8'h41);
        cur_req = "R6";
        dwr(8'h11); dwr(8'h22); dwr(8'h33);
        // R3: fetch on code 0, then R5 reads stream out
        cur_req = "R3";
        ctl(8'h23); ctl(8'h01);
        cur_req = "R5";
        drd(); idle(); chk("R5", "first read", int'(cpu_rdata), 8'h11);
        drd(); idle(); chk("R5", "second read", int'(cpu_rdata), 8'h22);
        drd(); idle(); chk("R5", "third read", int'(cpu_rdata), 8'h33);
        // R6: written byte lands in the buffer
        cur_req = "R6";
        dwr(8'h77); drd(); idle();
        chk("R6", "buffer copy", int'(cpu_rdata), 8'h77);

        // R6: colour table writes with code 3
        ctl(8'h05); ctl(8'hC0); dwr(8'hFF); dwr(8'h2A); idle();
        chk_pal("R6", 5, 8'h3F);
        chk_pal("R6", 6, 8'h2A);

        // R7: data access resets the toggle
        cur_req = "R7";
        ctl(8'h10); drd(); ctl(8'h40); ctl(8'h00); drd(); idle();
        chk("R7", "read after toggle reset", int'(cpu_rdata), (64 * 7 + 3) % 256);
        // R7: address wrap from 0x3FFF
        ctl(8'hFF); ctl(8'h7F); dwr(8'hAA); dwr(8'hBB);
        ctl(8'h00); ctl(8'h00); drd(); idle();
        chk("R7", "wrap to zero", int'(cpu_rdata), 8'hBB);

        // R10 / R8 / R9: frame path
        cur_req = "R10";
        @(negedge clk); cpu_rd = 0; cpu_wr = 0; frame_evt = 1; stat_evt = 7'h60;
        idle();
        chk("R10", "irq before enable", int'(irq), 0);
        ctl(8'h20); ctl(8'h81); idle();
        chk("R10", "irq after enable", int'(irq), 1);
        cur_req = "R8";
        srd(); idle();
        chk("R8", "status byte", int'(cpu_rdata), 8'hE0);
        chk("R9", "irq cleared", int'(irq), 0);
        // line path with forced low bits
        cur_req = "R10";
        ctl(8'h14); ctl(8'h80); idle();
        @(negedge clk); cpu_rd = 0; cpu_wr = 0; line_evt = 1;
        idle(); idle();
        chk("R10", "line irq", int'(irq), 1);
        cur_req = "R8";
        srd(); idle();
        chk("R8", "forced low bits", int'(cpu_rdata), 8'h1F);
        // R9: event in the same cycle as a status read survives
        cur_req = "R9";
        drive(1, 0, 1, 0); frame_evt = 1; idle(); idle();
        chk("R9", "same-cycle event irq", int'(irq), 1);
        srd(); idle();
        // R9: status read resets the toggle
        ctl(8'h44); srd(); ctl(8'h00); ctl(8'h02); drd(); idle();
        chk("R9", "toggle cleared by status", int'(cpu_rdata), (512 * 7 + 3) % 256);

        // R11: write wins over a simultaneous read
        cur_req = "R11";
        ctl(8'h30); ctl(8'h40); drive(1, 1, 0, 8'h9C);
        ctl(8'h30); ctl(8'h00); drd(); idle();
        chk("R11", "write taken", int'(cpu_rdata), 8'h9C);

        // mixed random traffic compared every clock
        cur_req = "R5";
        for (int n = 0; n < 6000; n++) begin
            int k;
            k = $urandom_range(0, 15);
            @(negedge clk);
            cpu_rd = (k < 5); cpu_wr = (k >= 4 && k < 11);
            cpu_sel = $urandom_range(0, 1);
            cpu_wdata = $urandom_range(0, 255);
            line_evt = ($urandom_range(0, 19) == 0);
            frame_evt = ($urandom_range(0, 29) == 0);
            stat_evt = ($urandom_range(0, 9) == 0) ? 7'($urandom_range(0, 127)) : 7'd0;
        end
        idle(); idle();
        for (int i = 0; i < 16; i++) chk_reg("R4", i, m_regs[i]);
        for (int i = 0; i < 32; i++) chk_pal("R6", i, m_cram[i]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule